// File: doc/BRIEF.md
# Byte-Wide Serial Memory Access Controller

This block sits between a host register bus and an external non-volatile byte memory. The host reaches the memory one byte at a time. It loads an address, raises a read or write request bit, and polls until the hardware drops that bit. A read leaves the fetched byte in the data register, and a write sends the data register's low byte out.

The block also has a burst mode that fills on-chip memory from the external part. Once started, the controller walks the external memory and reads three-byte records. Each record holds an address high byte, an address low byte and a data byte. The data byte goes to on-chip memory at an address made from a 9-bit base register and the low 15 bits of the record address.

The first burst after reset starts at external address 0. Any later burst picks up just after the last byte touched by any access. The external side is an abstract request/acknowledge byte port, and the on-chip side is a single write strobe with a 24-bit address.

Top module: `eep_access_ctrl`

## Requirements
- R1: After reset, every host register reads 0, `eeReq` is low and `memWe` is low. The register word indices on `hostAddr` are: 0 control, 1 address, 2 data, 3 burst start, 4 base.
- R2: Writing control with bit 1 set reads the byte at the address register into the data register (bits 7:0). Bit 1 reads 1 until the byte has arrived and then reads 0.
- R3: Writing control with bit 0 set and bit 1 clear sends data register bits 7:0 to the external address held in the address register. Bit 0 reads 0 once the write has completed.
- R4: `eeReq` stays high with `eeAddr`, `eeWe` and `eeWdata` unchanged until the cycle `eeAck` is seen. Each single access makes exactly one acknowledged transfer.
- R5: Writing 1 to bit 0 of the burst-start register starts a burst, and that bit reads 0 again when the burst ends. Each record is read as high byte, low byte, then data byte, and produces one `memWe` pulse. That pulse carries `memAddr = {base[8:0], word[14:0]}` and `memData` equal to the data byte, so bit 15 of the record address is dropped.
- R6: A burst started after reset and before any other access reads from external address 0.
- R7: In every other case, a burst begins at the address one above the last address accessed, whether by a single read, a single write or a burst.
- R8: A record whose address word is 16'hFFFF ends the burst. It produces no memory write and has no data byte.
- R9: The burst also ends after the byte at the top external address is read. A record left incomplete there is dropped, and the next access continues from address 0.
- R10: Control bit 2 reads 1 while any operation runs. Host writes to any register during that time are ignored, and only one operation is ever in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Host register word index |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for `hostAddr` (combinational) |
| eeReq | output | 1 | External byte transfer request |
| eeWe | output | 1 | Transfer is a write |
| eeAddr | output | EE_AW | External byte address |
| eeWdata | output | 8 | External write byte |
| eeAck | input | 1 | Transfer done; read byte valid on `eeRdata` |
| eeRdata | input | 8 | External read byte |
| memWe | output | 1 | On-chip memory write strobe |
| memAddr | output | BASE_W+LOW_W | On-chip memory byte address |
| memData | output | 8 | On-chip memory write byte |

## Verification
Single reads sweep all 256 external addresses with acknowledge latencies of 0 to 3 cycles, so a late-capture or wrong-address fault shows up as a mismatch in one byte. A band of single writes with a distinct data pattern separates the write path from the read path. Five bursts are chained so that each start point proves something different: reset start at 0, continuation after a terminator, continuation after a single read, a stop at the top with a half record, and restart after wrap. Together they also exercise two base values and a record address with bit 15 set. A slow read with register writes arriving during it shows whether busy blocking holds.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // host register word indices
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_ADDR  = 3'd1,
    REG_DATA  = 3'd2,
    REG_START = 3'd3,
    REG_BASE  = 3'd4
  } regIdx_e;

  localparam int CTRL_WR_BIT   = 0;
  localparam int CTRL_RD_BIT   = 1;
  localparam int CTRL_BUSY_BIT = 2;

  // accepted host requests, decoded by the datapath
  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic doBurst;
  } hostReq_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic capHi;
    logic capLo;
    logic capByte;
    logic stepSeq;
    logic singleDone;
    logic burstEnd;
  } strobe_t;

endpackage

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int EE_AW  = 8,
  parameter int BASE_W = 9,
  parameter int LOW_W  = 15
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hostWe,
  input  logic [2:0]                hostAddr,
  input  logic [31:0]               hostWdata,
  output logic [31:0]               hostRdata,
  input  logic                      busy,
  input  strobe_t                   strb,
  output hostReq_t                  hostReq,
  output logic [EE_AW-1:0]          eeAddr,
  output logic                      eeWe,
  output logic [7:0]                eeWdata,
  input  logic                      eeAck,
  input  logic [7:0]                eeRdata,
  output logic [BASE_W+LOW_W-1:0]   memAddr,
  output logic [7:0]                memData,
  output logic                      termHit,
  output logic                      atTop
);

  localparam int MEM_AW = BASE_W + LOW_W;

  logic [EE_AW-1:0]  addrReg;
  logic [EE_AW-1:0]  seqAddr;
  logic [7:0]        dataReg;
  logic [BASE_W-1:0] baseReg;
  logic              rdPend;
  logic              wrPend;
  logic              burstOn;
  logic [7:0]        hiReg;
  logic [7:0]        loReg;
  logic [7:0]        byteReg;
  logic              accept;
  logic [15:0]       addrWord;

  assign accept = hostWe && !busy;

  always_comb begin
    hostReq = '0;
    if (accept && hostAddr == REG_CTRL) begin
      hostReq.doRead  = hostWdata[CTRL_RD_BIT];
      hostReq.doWrite = hostWdata[CTRL_WR_BIT] && !hostWdata[CTRL_RD_BIT];
    end
    if (accept && hostAddr == REG_START) hostReq.doBurst = hostWdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      seqAddr <= '0;
      dataReg <= '0;
      baseReg <= '0;
      rdPend  <= 1'b0;
      wrPend  <= 1'b0;
      burstOn <= 1'b0;
      hiReg   <= '0;
      loReg   <= '0;
      byteReg <= '0;
    end else begin
      if (accept) begin
        case (hostAddr)
          REG_ADDR: addrReg <= hostWdata[EE_AW-1:0];
          REG_DATA: dataReg <= hostWdata[7:0];
          REG_BASE: baseReg <= hostWdata[BASE_W-1:0];
          default:  ;
        endcase
      end
      if (hostReq.doRead)  rdPend  <= 1'b1;
      if (hostReq.doWrite) wrPend  <= 1'b1;
      if (hostReq.doBurst) burstOn <= 1'b1;
      if (strb.singleDone) begin
        rdPend  <= 1'b0;
        wrPend  <= 1'b0;
        seqAddr <= addrReg + 1'b1;
        if (rdPend) dataReg <= eeRdata;
      end
      if (strb.capHi)   hiReg   <= eeRdata;
      if (strb.capLo)   loReg   <= eeRdata;
      if (strb.capByte) byteReg <= eeRdata;
      if (strb.stepSeq) seqAddr <= seqAddr + 1'b1;
      if (strb.burstEnd) burstOn <= 1'b0;
    end
  end

  // external port: burst walks the sequence pointer, singles use the host address
  assign eeAddr  = burstOn ? seqAddr : addrReg;
  assign eeWe    = wrPend;
  assign eeWdata = dataReg;
  assign atTop   = (eeAddr == {EE_AW{1'b1}});
  assign termHit = ({hiReg, eeRdata} == 16'hFFFF);

  assign addrWord = {hiReg, loReg};
  assign memAddr  = {baseReg, addrWord[LOW_W-1:0]};
  assign memData  = byteReg;

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      REG_CTRL: begin
        hostRdata[CTRL_WR_BIT]   = wrPend;
        hostRdata[CTRL_RD_BIT]   = rdPend;
        hostRdata[CTRL_BUSY_BIT] = busy;
      end
      REG_ADDR:  hostRdata[EE_AW-1:0]  = addrReg;
      REG_DATA:  hostRdata[7:0]        = dataReg;
      REG_START: hostRdata[0]          = burstOn;
      REG_BASE:  hostRdata[BASE_W-1:0] = baseReg;
      default:   hostRdata = '0;
    endcase
  end

  initial begin
    if (MEM_AW != 24) $display("note: on-chip address width is %0d", MEM_AW);
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdPend, wrPend, burstOn})); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && busy) |=> ($stable(addrReg) && $stable(baseReg))); // R10
  AST_RD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdPend && eeAck) |=> !rdPend); // R2
  AST_WR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && eeAck) |=> !wrPend); // R3

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  hostReq_t hostReq,
  input  logic     eeAck,
  input  logic     termHit,
  input  logic     atTop,
  output strobe_t  strb,
  output logic     eeReq,
  output logic     memWe,
  output logic     busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_SREQ, ST_BREQ, ST_BNEXT} state_e;

  state_e     state, stateNx;
  logic [1:0] phase, phaseNx;
  logic       stopReg, stopNx;
  logic       writeNow, writeNowNx;

  always_comb begin
    stateNx    = state;
    phaseNx    = phase;
    stopNx     = stopReg;
    writeNowNx = writeNow;
    strb       = '0;
    case (state)
      ST_IDLE: begin
        if (hostReq.doRead || hostReq.doWrite) stateNx = ST_SREQ;
        else if (hostReq.doBurst) begin
          stateNx = ST_BREQ;
          phaseNx = 2'd0;
        end
      end
      ST_SREQ: begin
        if (eeAck) begin
          strb.singleDone = 1'b1;
          stateNx = ST_IDLE;
        end
      end
      ST_BREQ: begin
        if (eeAck) begin
          strb.stepSeq = 1'b1;
          strb.capHi   = (phase == 2'd0);
          strb.capLo   = (phase == 2'd1);
          strb.capByte = (phase == 2'd2);
          phaseNx      = (phase == 2'd2) ? 2'd0 : phase + 2'd1;
          stopNx       = atTop || ((phase == 2'd1) && termHit);
          writeNowNx   = (phase == 2'd2);
          stateNx      = ST_BNEXT;
        end
      end
      ST_BNEXT: begin
        if (stopReg) begin
          strb.burstEnd = 1'b1;
          stateNx = ST_IDLE;
        end else begin
          stateNx = ST_BREQ;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 2'd0;
      stopReg  <= 1'b0;
      writeNow <= 1'b0;
    end else begin
      state    <= stateNx;
      phase    <= phaseNx;
      stopReg  <= stopNx;
      writeNow <= writeNowNx;
    end
  end

  assign eeReq = (state == ST_SREQ) || (state == ST_BREQ);
  assign memWe = (state == ST_BNEXT) && writeNow;
  assign busy  = (state != ST_IDLE);

  AST_DATA_BYTE_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BREQ && eeAck && phase == 2'd2) |=> memWe); // R5
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BNEXT && stopReg) |=> !busy); // R8

endmodule

// File: rtl/eep_access_ctrl.sv
module eep_access_ctrl
  import eep_pkg::*;
#(
  parameter int EE_AW  = 8,
  parameter int BASE_W = 9,
  parameter int LOW_W  = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostWe,
  input  logic [2:0]              hostAddr,
  input  logic [31:0]             hostWdata,
  output logic [31:0]             hostRdata,
  output logic                    eeReq,
  output logic                    eeWe,
  output logic [EE_AW-1:0]        eeAddr,
  output logic [7:0]              eeWdata,
  input  logic                    eeAck,
  input  logic [7:0]              eeRdata,
  output logic                    memWe,
  output logic [BASE_W+LOW_W-1:0] memAddr,
  output logic [7:0]              memData
);

  hostReq_t hostReq;
  strobe_t  strb;
  logic     busy;
  logic     termHit;
  logic     atTop;

  eep_datapath #(.EE_AW(EE_AW), .BASE_W(BASE_W), .LOW_W(LOW_W)) u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busy(busy), .strb(strb),
    .hostReq(hostReq), .eeAddr(eeAddr), .eeWe(eeWe), .eeWdata(eeWdata),
    .eeAck(eeAck), .eeRdata(eeRdata), .memAddr(memAddr), .memData(memData),
    .termHit(termHit), .atTop(atTop)
  );

  eep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .eeAck(eeAck),
    .termHit(termHit), .atTop(atTop), .strb(strb), .eeReq(eeReq),
    .memWe(memWe), .busy(busy)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (eeReq && !eeAck) |=> (eeReq && $stable(eeAddr) && $stable(eeWe) && $stable(eeWdata))); // R4

endmodule

// File: tb/test_eep_access_ctrl.sv
`timescale 1ns/1ps
module test_eep_access_ctrl;
  import eep_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWe;
  logic [2:0]  hostAddr;
  logic [31:0] hostWdata;
  logic [31:0] hostRdata;
  logic        eeReq, eeWe, eeAck;
  logic [7:0]  eeAddr, eeWdata, eeRdata;
  logic        memWe;
  logic [23:0] memAddr;
  logic [7:0]  memData;

  always #10 clk = ~clk;

  eep_access_ctrl #(.EE_AW(8), .BASE_W(9), .LOW_W(15)) i_eep_access_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .eeReq(eeReq), .eeWe(eeWe),
    .eeAddr(eeAddr), .eeWdata(eeWdata), .eeAck(eeAck), .eeRdata(eeRdata),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // behavioural external memory
  logic [7:0] mem [0:255];
  int lat = 1;
  int cnt;
  int txCount = 0;
  int holdErr = 0;
  logic       holdValid;
  logic [7:0] heldAddr;
  logic       heldWe;

  always @(posedge clk) begin
    if (!rstN) begin
      eeAck <= 1'b0; cnt <= 0; holdValid <= 1'b0; eeRdata <= 8'h00;
    end else begin
      if (holdValid && (!eeReq || eeAddr !== heldAddr || eeWe !== heldWe)) holdErr++;
      holdValid <= eeReq && !eeAck;
      heldAddr  <= eeAddr;
      heldWe    <= eeWe;
      if (eeAck) begin
        eeAck <= 1'b0; cnt <= 0;
      end else if (eeReq) begin
        if (cnt >= lat) begin
          eeAck <= 1'b1;
          txCount++;
          if (eeWe) mem[eeAddr] <= eeWdata;
          else eeRdata <= mem[eeAddr];
        end else cnt <= cnt + 1;
      end
    end
  end

  // on-chip memory write log
  logic [23:0] logA [0:15];
  logic [7:0]  logD [0:15];
  int logN = 0;
  always @(posedge clk) begin
    if (rstN && memWe) begin
      if (logN < 16) begin logA[logN] <= memAddr; logD[logN] <= memData; end
      logN <= logN + 1;
    end
  end

  function automatic logic [7:0] patt(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] wpatt(int i);
    return 8'(((i * 13) & 255) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] initAt(int i);
    case (i)
      0: return 8'h81;   1: return 8'h23;   2: return 8'hA5;
      3: return 8'h00;   4: return 8'h07;   5: return 8'h3C;
      6: return 8'hFF;   7: return 8'hFF;
      8: return 8'h00;   9: return 8'h55;   10: return 8'h77;
      11: return 8'hFF;  12: return 8'hFF;
      101: return 8'h12; 102: return 8'h34; 103: return 8'h9E;
      104: return 8'hFF; 105: return 8'hFF;
      251: return 8'h02; 252: return 8'h22; 253: return 8'h44;
      254: return 8'h01; 255: return 8'h11;
      default: return patt(i);
    endcase
  endfunction
  function automatic logic [7:0] expAt(int i);
    if (i >= 128 && i < 192) return wpatt(i);
    return initAt(i);
  endfunction
  function automatic logic [23:0] memExp(int base, int word);
    return 24'((base << 15) | (word & 32'h7FFF));
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    hostAddr = idx; hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(logic [2:0] idx, output logic [31:0] v);
    @(negedge clk);
    hostAddr = idx;
    #1 v = hostRdata;
  endtask

  task automatic waitIdle(string req);
    logic [31:0] v;
    int n = 0;
    do begin
      hostRead(REG_CTRL, v);
      n++;
    end while (v[2] && n < 3000);
    check(!v[2], req, "operation never finished", v, 0);
  endtask

  task automatic runBurst(string req);
    logic [31:0] v;
    hostWrite(REG_START, 32'h1);
    hostRead(REG_START, v);
    check(v[0] == 1'b1, "R5", "start bit while running", v, 1);
    waitIdle(req);
    hostRead(REG_START, v);
    check(v == 0, "R5", "start bit after burst", v, 0);
  endtask

  task automatic singleRead(int a, output logic [31:0] v);
    hostWrite(REG_ADDR, 32'(a));
    hostWrite(REG_CTRL, 32'h2);
    waitIdle("R2");
    hostRead(REG_DATA, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired before the test finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int tx0;
    for (int i = 0; i < 256; i++) mem[i] = initAt(i);
    rstN = 1'b0; hostWe = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      hostRead(3'(r), v);
      check(v == 0, "R1", $sformatf("register %0d after reset", r), v, 0);
    end
    check(!eeReq && !memWe, "R1", "eeReq/memWe after reset", {eeReq, memWe}, 0);

    // R6 first burst starts at 0; R8 terminator; R5 address formation
    hostWrite(REG_BASE, 32'h1AB);
    runBurst("R6");
    check(logN == 2, "R8", "writes in first burst", logN, 2);
    check(logA[0] == memExp(32'h1AB, 32'h8123), "R6", "first record address", logA[0], memExp(32'h1AB, 32'h8123));
    check(logD[0] == 8'hA5, "R5", "first record data", logD[0], 8'hA5);
    check(logA[1] == memExp(32'h1AB, 32'h0007), "R5", "second record address", logA[1], memExp(32'h1AB, 32'h0007));
    check(logD[1] == 8'h3C, "R5", "second record data", logD[1], 8'h3C);

    // R7 continuation after a burst
    runBurst("R7");
    check(logN == 3, "R7", "writes after second burst", logN, 3);
    check(logA[2] == memExp(32'h1AB, 32'h0055) && logD[2] == 8'h77, "R7",
          "burst after burst", logA[2], memExp(32'h1AB, 32'h0055));

    // R7 continuation after a single read
    lat = 2;
    singleRead(100, v);
    check(v[7:0] == initAt(100), "R2", "read at 100", v, initAt(100));
    hostWrite(REG_BASE, 32'h055);
    runBurst("R7");
    check(logN == 4, "R7", "writes after third burst", logN, 4);
    check(logA[3] == memExp(32'h055, 32'h1234) && logD[3] == 8'h9E, "R7",
          "burst after single read", logA[3], memExp(32'h055, 32'h1234));

    // R9 wrap at the top drops the half record
    singleRead(250, v);
    runBurst("R9");
    check(logN == 5, "R9", "writes in wrapping burst", logN, 5);
    check(logA[4] == memExp(32'h055, 32'h0222) && logD[4] == 8'h44, "R9",
          "record before top", logA[4], memExp(32'h055, 32'h0222));
    runBurst("R9");
    check(logN == 7, "R9", "writes after wrap restart", logN, 7);
    check(logA[5] == memExp(32'h055, 32'h0123) && logD[5] == 8'hA5, "R9",
          "restart from address 0", logA[5], memExp(32'h055, 32'h0123));

    // R10 busy status and ignored writes
    lat = 8;
    tx0 = txCount;
    hostWrite(REG_ADDR, 32'd20);
    hostWrite(REG_CTRL, 32'h2);
    hostRead(REG_CTRL, v);
    check(v[2:0] == 3'b110, "R10", "control while reading", v[2:0], 3'b110);
    hostWrite(REG_ADDR, 32'd30);
    hostWrite(REG_CTRL, 32'h1);
    hostWrite(REG_DATA, 32'hEE);
    hostWrite(REG_START, 32'h1);
    waitIdle("R10");
    hostRead(REG_ADDR, v);
    check(v == 20, "R10", "address register after busy write", v, 20);
    hostRead(REG_DATA, v);
    check(v == expAt(20), "R10", "data register after busy write", v, expAt(20));
    hostRead(REG_START, v);
    check(v == 0, "R10", "burst start ignored while busy", v, 0);
    check(txCount == tx0 + 1, "R10", "transfers during busy test", txCount, tx0 + 1);
    check(logN == 7, "R10", "no burst from ignored start", logN, 7);

    // R3 single write sweep
    for (int i = 128; i < 192; i++) begin
      lat = i % 3;
      hostWrite(REG_ADDR, 32'(i));
      hostWrite(REG_DATA, 32'(wpatt(i)));
      hostWrite(REG_CTRL, 32'h1);
      if (i == 128) begin
        hostRead(REG_CTRL, v);
        check(v[0] == 1'b1, "R3", "write bit while pending", v, 1);
      end
      waitIdle("R3");
      hostRead(REG_CTRL, v);
      check(v == 0, "R3", "control after write", v, 0);
      check(mem[i] == wpatt(i), "R3", $sformatf("external byte %0d", i), mem[i], wpatt(i));
    end

    // R2 full single read sweep, R4 one transfer per access
    tx0 = txCount;
    for (int i = 0; i < 256; i++) begin
      lat = i % 4;
      singleRead(i, v);
      check(v == expAt(i), "R2", $sformatf("read at %0d", i), v, expAt(i));
    end
    check(txCount == tx0 + 256, "R4", "transfers in read sweep", txCount, tx0 + 256);
    check(holdErr == 0, "R4", "request hold violations", holdErr, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule